// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This controller turns one PWM command into two gate enables for a synchronous buck stage. One enable is for the high-side switch and one is for the low-side switch. When the controller is enabled, the high-side enable follows the PWM level and the low-side enable takes the opposite level. The two enables never overlap. Between the moment one enable drops and the moment the other rises, a dead-time interval runs. That interval adapts to two comparator flags that the analog front end has already digitised:

- `node_low_i` reports the switch node below 1 V.
- `gate_low_i` reports the low-side gate below one sixth of the supply.

All four asynchronous inputs pass through flop synchronisers before the state machine uses them. The active-low kill input also removes both enables at once, with no clock involved. Every delay is a whole number of clock cycles set by a parameter. The defaults assume a 100 MHz clock: 15 cycles for the fixed delay, 19 cycles for the timeout and 3 cycles for the added delay. Cycle counts below are for the default of two synchroniser stages. An input change made between edges is first acted on by the state machine at the third rising edge after it.

Top module: `gate_deadtime_ctrl`

## Requirements
- R1: While reset is asserted, and while the kill input is low after reset, `hs_en_o` and `ls_en_o` are both 0.
- R2: `hs_en_o` and `ls_en_o` are never 1 in the same cycle.
- R3: A 0 on `kill_n_i` drives both enables to 0 in the same cycle, before any clock edge, whatever the state. The controller stays in its off state for as long as the synchronised kill reads 0.
- R4: Each input passes through SYNC_STAGES flops (default 2). A PWM change made between edges changes the outputs at the third rising edge after it: after the first and second edges the old output is still present.
- R5: Once a dead time completes, `hs_en_o` is 1 while PWM is 1 and `ls_en_o` is 1 while PWM is 0. Both hold their value while PWM is steady.
- R6: On PWM falling, `hs_en_o` drops at the edge where the synchronised PWM reads 0. If `node_low_i` has read 0 (node high) at an earlier edge of the wait and then reads 1, `ls_en_o` rises at that edge.
- R7: If `node_low_i` reads 1 throughout the wait, `ls_en_o` rises FIX_CYC cycles after `hs_en_o` dropped.
- R8: If the node stays high (`node_low_i` = 0), `ls_en_o` still rises TMO_CYC cycles after `hs_en_o` dropped.
- R9: On PWM rising, `ls_en_o` drops at the edge where the synchronised PWM reads 1. `hs_en_o` rises at the LH_CYC-th edge, counted inclusively from the first edge at which the synchronised `gate_low_i` reads 1. That first reading is latched for the rest of the wait.
- R10: If PWM reverses during a wait, the pending turn-on is dropped. Both enables stay 0, and a fresh wait for the new direction starts with its cycle count at zero.
- R11: When the synchronised kill returns to 1, the controller leaves its off state through the dead-time wait for the current PWM level (R6 to R9). No enable is asserted directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | PWM command, asynchronous |
| kill_n_i | input | 1 | Active-low output kill, asynchronous |
| node_low_i | input | 1 | 1 = switch node below 1 V |
| gate_low_i | input | 1 | 1 = low-side gate below one sixth of supply |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
The assertions relate state, timer and outputs across edges. They assume that PWM and the flags are ordinary levels held for at least one clock. They also assume that the kill input is the only path that removes an enable without a clock. The bench changes every input only on falling clock edges, so each value is sampled cleanly by the synchronisers. It drives the flag waveforms as a converter stage would show them: the node staying low, the node going high then falling, the node stuck high, and the gate flag arriving late. A long stretch of pseudo-random PWM, flag and kill activity follows, all at clock granularity, so no assumption is stretched.

// File: rtl/gdt_pkg.sv
`timescale 1ns/1ps
package gdt_pkg;
   typedef enum logic [2:0] {
      GS_OFF     = 3'd0,
      GS_LS_ON   = 3'd1,
      GS_WAIT_LH = 3'd2,
      GS_HS_ON   = 3'd3,
      GS_WAIT_HL = 3'd4
   } gdt_state_e;

   localparam int unsigned IN_PWM  = 0;
   localparam int unsigned IN_EN   = 1;
   localparam int unsigned IN_NODE = 2;
   localparam int unsigned IN_GATE = 3;
   localparam int unsigned IN_NUM  = 4;
endpackage

// File: rtl/gdt_sync_bank.sv
`timescale 1ns/1ps
module gdt_sync_bank #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   initial begin
      assert (STAGES >= 2) else $error("gdt_sync_bank: STAGES must be at least 2");
      assert (WIDTH >= 1)  else $error("gdt_sync_bank: WIDTH must be at least 1");
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_n_i) begin
         if (!rst_n_i) chain_q <= '0;
         else          chain_q <= {chain_q[STAGES-2:0], d_i[g]};
      end
      assign q_o[g] = chain_q[STAGES-1];
   end
endmodule

// File: rtl/gdt_timer.sv
`timescale 1ns/1ps
module gdt_timer #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)                        cnt_o <= '0;
      else if (clr_i)                      cnt_o <= '0;
      else if (inc_i && cnt_o != CNT_TOP)  cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/gdt_fsm.sv
`timescale 1ns/1ps
module gdt_fsm
   import gdt_pkg::*;
#(
   parameter int unsigned FIX_CYC = 15,
   parameter int unsigned TMO_CYC = 19,
   parameter int unsigned LH_CYC  = 3,
   parameter int unsigned CNT_W   = 5
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             pwm_s_i,
   input  logic             en_s_i,
   input  logic             node_low_s_i,
   input  logic             gate_low_s_i,
   input  logic [CNT_W-1:0] tmr_i,
   output logic             tmr_clr_o,
   output logic             tmr_inc_o,
   output logic             hs_o,
   output logic             ls_o
);
   localparam logic [CNT_W-1:0] FIX_LIM = CNT_W'(FIX_CYC - 1);
   localparam logic [CNT_W-1:0] TMO_LIM = CNT_W'(TMO_CYC - 1);
   localparam logic [CNT_W-1:0] LH_LIM  = CNT_W'(LH_CYC - 1);

   gdt_state_e state_q, state_d;
   logic       seen_q, seen_d;
   logic       ls_go, hs_armed;

   // low-side may go: node low after seen high, node low past fixed delay, or timeout
   assign ls_go    = (node_low_s_i && (seen_q || tmr_i >= FIX_LIM)) || (tmr_i >= TMO_LIM);
   assign hs_armed = seen_q || gate_low_s_i;

   always_comb begin
      state_d   = state_q;
      seen_d    = seen_q;
      tmr_inc_o = 1'b0;
      if (!en_s_i) begin
         state_d = GS_OFF;
      end else begin
         unique case (state_q)
            GS_OFF:    state_d = pwm_s_i ? GS_WAIT_LH : GS_WAIT_HL;
            GS_LS_ON:  if (pwm_s_i)  state_d = GS_WAIT_LH;
            GS_HS_ON:  if (!pwm_s_i) state_d = GS_WAIT_HL;
            GS_WAIT_HL: begin
               if (pwm_s_i)    state_d = GS_WAIT_LH;
               else if (ls_go) state_d = GS_LS_ON;
               else begin
                  tmr_inc_o = 1'b1;
                  if (!node_low_s_i) seen_d = 1'b1;
               end
            end
            GS_WAIT_LH: begin
               if (!pwm_s_i) state_d = GS_WAIT_HL;
               else if (hs_armed) begin
                  if (tmr_i >= LH_LIM) state_d = GS_HS_ON;
                  else begin
                     tmr_inc_o = 1'b1;
                     seen_d    = 1'b1;
                  end
               end
            end
            default:   state_d = GS_OFF;
         endcase
      end
      tmr_clr_o = (state_d != state_q);
      if (tmr_clr_o) seen_d = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         state_q <= GS_OFF;
         seen_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         seen_q  <= seen_d;
      end
   end

   assign hs_o = (state_q == GS_HS_ON);
   assign ls_o = (state_q == GS_LS_ON);

   assert_kill_forces_off_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !en_s_i |=> (state_q == GS_OFF));
   assert_ls_after_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(ls_o) |-> ($past(state_q) == GS_WAIT_HL));
   assert_wait_bounded_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (state_q == GS_WAIT_HL) |-> (tmr_i <= TMO_LIM));
   assert_hs_needs_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(hs_o) |-> $past(seen_q || gate_low_s_i));
   assert_reversal_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (state_q == GS_WAIT_HL && en_s_i && pwm_s_i) |=> (state_q == GS_WAIT_LH && tmr_i == '0));
   assert_off_exits_via_wait_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (state_q == GS_OFF) |=> (!hs_o && !ls_o));
endmodule

// File: rtl/gate_deadtime_ctrl.sv
`timescale 1ns/1ps
module gate_deadtime_ctrl
   import gdt_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FIX_CYC     = 15,
   parameter int unsigned TMO_CYC     = 19,
   parameter int unsigned LH_CYC      = 3
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic pwm_i,
   input  logic kill_n_i,
   input  logic node_low_i,
   input  logic gate_low_i,
   output logic hs_en_o,
   output logic ls_en_o
);
   localparam int unsigned MAX_A   = (FIX_CYC > TMO_CYC) ? FIX_CYC : TMO_CYC;
   localparam int unsigned CNT_MAX = (MAX_A > LH_CYC) ? MAX_A : LH_CYC;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   initial begin
      assert (FIX_CYC >= 1)       else $error("gate_deadtime_ctrl: FIX_CYC must be at least 1");
      assert (TMO_CYC >= FIX_CYC) else $error("gate_deadtime_ctrl: TMO_CYC must not be below FIX_CYC");
      assert (LH_CYC >= 1)        else $error("gate_deadtime_ctrl: LH_CYC must be at least 1");
   end

   logic [IN_NUM-1:0] raw_in, syn_in;
   logic [CNT_W-1:0]  tmr;
   logic              tmr_clr, tmr_inc, hs_q, ls_q;

   always_comb begin
      raw_in          = '0;
      raw_in[IN_PWM]  = pwm_i;
      raw_in[IN_EN]   = kill_n_i;
      raw_in[IN_NODE] = node_low_i;
      raw_in[IN_GATE] = gate_low_i;
   end

   gdt_sync_bank #(.WIDTH(IN_NUM), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .d_i     (raw_in),
      .q_o     (syn_in)
   );

   gdt_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .clr_i   (tmr_clr),
      .inc_i   (tmr_inc),
      .cnt_o   (tmr)
   );

   gdt_fsm #(
      .FIX_CYC (FIX_CYC),
      .TMO_CYC (TMO_CYC),
      .LH_CYC  (LH_CYC),
      .CNT_W   (CNT_W)
   ) u_fsm (
      .clk_i        (clk_i),
      .rst_n_i      (rst_n_i),
      .pwm_s_i      (syn_in[IN_PWM]),
      .en_s_i       (syn_in[IN_EN]),
      .node_low_s_i (syn_in[IN_NODE]),
      .gate_low_s_i (syn_in[IN_GATE]),
      .tmr_i        (tmr),
      .tmr_clr_o    (tmr_clr),
      .tmr_inc_o    (tmr_inc),
      .hs_o         (hs_q),
      .ls_o         (ls_q)
   );

   // kill acts without waiting for the synchronisers
   assign hs_en_o = hs_q & kill_n_i;
   assign ls_en_o = ls_q & kill_n_i;
endmodule

// File: tb/tb_gate_deadtime_ctrl.sv
`timescale 1ns/1ps
module tb_gate_deadtime_ctrl;
   localparam int SYNC = 2;
   localparam int FIX  = 15;
   localparam int TMO  = 19;
   localparam int LH   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm = 1'b0, kill_n = 1'b0, nlow = 1'b1, glow = 1'b1;
   logic hs, ls;

   int    vectors = 0;
   int    miscomp = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   gate_deadtime_ctrl #(.SYNC_STAGES(SYNC), .FIX_CYC(FIX), .TMO_CYC(TMO), .LH_CYC(LH)) dut (
      .clk_i(clk), .rst_n_i(rst_n), .pwm_i(pwm), .kill_n_i(kill_n),
      .node_low_i(nlow), .gate_low_i(glow), .hs_en_o(hs), .ls_en_o(ls)
   );

   // behavioural reference: 0 off, 1 low on, 2 wait to high, 3 high on, 4 wait to low
   int         m_st, m_t;
   bit         m_seen;
   logic [3:0] h1, h2;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_t = 0; m_seen = 0; h1 = '0; h2 = '0;
      end else begin
         int nxt;
         logic p, e, nl, gl;
         {gl, nl, e, p} = h2;
         nxt = m_st;
         if (!e) nxt = 0;
         else if (m_st == 0) nxt = p ? 2 : 4;
         else if (m_st == 1) begin if (p) nxt = 2; end
         else if (m_st == 3) begin if (!p) nxt = 4; end
         else if (m_st == 4) begin
            if (p) nxt = 2;
            else if ((nl && (m_seen || m_t >= FIX - 1)) || m_t >= TMO - 1) nxt = 1;
            else begin m_t++; if (!nl) m_seen = 1; end
         end else begin
            if (!p) nxt = 4;
            else if (m_seen || gl) begin
               if (m_t >= LH - 1) nxt = 3;
               else begin m_t++; m_seen = 1; end
            end
         end
         if (nxt != m_st) begin m_t = 0; m_seen = 0; end
         m_st = nxt;
         h2 = h1;
         h1 = {glow, nlow, kill_n, pwm};
      end
   end

   // per-cycle comparison, away from the rising edge
   always @(negedge clk) begin
      logic ehs, els;
      #1;
      ehs = rst_n && (m_st == 3) && kill_n;
      els = rst_n && (m_st == 1) && kill_n;
      vectors++;
      if (hs !== ehs || ls !== els) begin
         miscomp++;
         $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b at cycle %0d", cur_req, hs, ls, ehs, els, cyc);
      end
      if (hs === 1'b1 && ls === 1'b1) begin
         miscomp++;
         $display("FAIL R2: hs=1 ls=1 expected not both high at cycle %0d", cyc);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_pair(input string tag, input logic ehs, input logic els);
      vectors++;
      if (hs !== ehs || ls !== els) begin
         miscomp++;
         $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", tag, hs, ls, ehs, els);
      end
   endtask

   // count falling edges until the chosen enable reads 1
   task automatic measure(input string tag, input bit use_hs, input int exp_k);
      int k;
      k = 0;
      for (int i = 1; i <= 80; i++) begin
         @(negedge clk); #2;
         if ((use_hs ? hs : ls) === 1'b1) begin k = i; break; end
      end
      vectors++;
      if (k != exp_k) begin
         miscomp++;
         $display("FAIL %s: rise after %0d cycles, expected %0d", tag, k, exp_k);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000 && !done) begin
         done = 1'b1;
         miscomp++;
         $display("FAIL watchdog: run still active after %0d cycles, expected completion", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
         $finish;
      end
   end

   initial begin
      // R1: reset and kill-held state
      step(3); #2;
      check_pair("R1 in reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      step(6); #2;
      check_pair("R1 kill held low", 1'b0, 1'b0);

      // R11: leave off state with PWM low, node flag low-side reading 1 -> fixed delay
      cur_req = "R11";
      kill_n = 1'b1;
      measure("R11 exit to low side", 1'b0, SYNC + 1 + FIX);
      cur_req = "R5";
      step(5); #2;
      check_pair("R5 pwm low steady", 1'b0, 1'b1);

      // R9: gate flag already set
      cur_req = "R9";
      pwm = 1'b1;
      measure("R9 gate ready", 1'b1, SYNC + 1 + LH);
      cur_req = "R5";
      step(5); #2;
      check_pair("R5 pwm high steady", 1'b1, 1'b0);

      // R4: latency of a PWM change
      @(negedge clk);
      cur_req = "R4";
      pwm = 1'b0;
      @(negedge clk); #2; check_pair("R4 after first edge", 1'b1, 1'b0);
      @(negedge clk); #2; check_pair("R4 after second edge", 1'b1, 1'b0);
      @(negedge clk); #2; check_pair("R4 after third edge", 1'b0, 1'b0);
      step(25);

      // R7: node stays low -> fixed delay
      cur_req = "R7";
      pwm = 1'b1; step(12);
      pwm = 1'b0;
      measure("R7 fixed delay", 1'b0, SYNC + 1 + FIX);

      // R8: node stuck high -> timeout
      cur_req = "R8";
      pwm = 1'b1; step(12);
      nlow = 1'b0; pwm = 1'b0;
      measure("R8 timeout", 1'b0, SYNC + 1 + TMO);

      // R6: node high then falling
      cur_req = "R6";
      pwm = 1'b1; step(12);
      pwm = 1'b0; step(5);
      nlow = 1'b1;
      measure("R6 adaptive", 1'b0, SYNC + 1);

      // R9: gate flag late
      cur_req = "R9";
      glow = 1'b0; pwm = 1'b1; step(6);
      glow = 1'b1;
      measure("R9 gate late", 1'b1, SYNC + LH);

      // R10: reversal from the high-to-low wait
      cur_req = "R10";
      nlow = 1'b0; pwm = 1'b0; step(10);
      pwm = 1'b1; glow = 1'b1;
      measure("R10 reverse to high", 1'b1, SYNC + 1 + LH);

      // R10: reversal from the low-to-high wait
      nlow = 1'b1; pwm = 1'b0; step(25);
      glow = 1'b0; pwm = 1'b1; step(8); #1;
      check_pair("R10 both off in wait", 1'b0, 1'b0);
      @(negedge clk);
      pwm = 1'b0;
      measure("R10 reverse to low", 1'b0, SYNC + 1 + FIX);

      // R3: immediate kill
      cur_req = "R3";
      glow = 1'b1; pwm = 1'b1; step(12);
      kill_n = 1'b0; #1;
      check_pair("R3 same cycle", 1'b0, 1'b0);
      step(10); #2;
      check_pair("R3 held", 1'b0, 1'b0);

      // R11: re-enable with PWM high
      cur_req = "R11";
      kill_n = 1'b1;
      measure("R11 exit to high side", 1'b1, SYNC + 1 + LH);

      // R2: pseudo-random activity checked against the reference every cycle
      cur_req = "R2";
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if ($urandom_range(0, 11) == 0) pwm = ~pwm;
         if ($urandom_range(0, 3) == 0) nlow = $urandom_range(0, 1) == 1;
         if ($urandom_range(0, 3) == 0) glow = $urandom_range(0, 2) != 0;
         if (!kill_n) kill_n = $urandom_range(0, 5) == 0;
         else if ($urandom_range(0, 199) == 0) kill_n = 1'b0;
      end
      kill_n = 1'b1;
      step(40);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
   end
endmodule